// File: doc/BRIEF.md
# MSI Message Ring-Buffer Controller

This block collects inbound message-signalled interrupt writes and records each one as a 16-byte entry in a circular queue in system memory. For every accepted message it sends one memory-write request carrying the entry. It then moves its hardware write offset forward, wrapping at the selected queue size. Software drains the queue by reading entries at its own read offset and writing the advanced offset back. A single level interrupt tells the host that unread entries remain.

A small register port sets the block up. The registers hold a control word, the 64-bit queue base split into two 32-bit halves, the software read offset and the hardware write offset. The control word selects a queue of 32, 64, 128 or 256 KB. It also chooses what happens when the queue fills: either new messages are dropped and a sticky overflow flag is set, or the oldest entry is overwritten and the read offset is pushed forward.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset every register reads zero, `irqOut` is low, `memWrValid` is low and capture is disabled.
- R2: Registers sit at word addresses 0 (control), 3 (base high), 4 (base low), 5 (read offset) and 6 (write offset). The write offset is read-only. Every other address reads zero, and writes to it change nothing.
- R3: Control bit 0 enables capture, bit 1 enables the full flag, bit 3 enables the interrupt, bit 4 enables stop-on-full and bits 9:8 hold the size code. These bits read back as written. Read bit 30 shows the full condition when bit 1 is set. Read bit 31 is the sticky overflow flag, and writing control with bit 31 set clears it.
- R4: Each accepted message produces, on the next cycle, `memWrValid` high, `memWrAddr` = {base high, base low} + write offset and `memWrData` = {96 zero bits, message data}. The write offset then advances by 16 and wraps to zero at 2^(15+code) bytes.
- R5: While capture is disabled, messages cause no memory write and leave both offsets unchanged.
- R6: A write to the read offset is stored with bits 3:0 cleared and every bit at or above 15+code cleared.
- R7: A write to control re-masks both stored offsets to the newly selected size.
- R8: The queue is full when (write offset + 16) modulo the size equals the read offset. When full with stop-on-full set, a message is dropped: no memory write, no offset change, and the overflow flag is set.
- R9: When full with stop-on-full clear, a message is written and both the write offset and the read offset advance by 16 with wrap.
- R10: `irqOut` is high exactly when the interrupt enable is set and the read offset differs from the write offset.
- R11: If a read-offset register write and an overwriting message fall in the same cycle, the software value, masked as in R6, is what the read offset holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiValid | input | 1 | Inbound message write strobe |
| msiData | input | 32 | Inbound message data word |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| memWrValid | output | 1 | Memory-write request valid |
| memWrAddr | output | 64 | Memory-write byte address |
| memWrData | output | 128 | Memory-write entry |
| irqOut | output | 1 | Level summary interrupt |

## Verification
The hardest conditions to reach are the full queue and the wrap at the queue end. Filling even the smallest queue from empty takes over two thousand messages. The bench therefore reaches the full condition directly, by writing a read offset just one entry ahead of the write offset. It covers wrap with a long directed burst in the 32 KB setting. Constrained random traffic then mixes consumes, size changes and stop-on-full toggles, so that messages arrive while the queue is full, both with and without stop-on-full, and sometimes in the same cycle as a read-offset write.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int MIN_LOG   = 15;
  localparam int CODE_W    = 2;
  localparam int ENTRY_LOG = 4;
  localparam int MAX_LOG   = MIN_LOG + (1 << CODE_W) - 1;
  localparam int OFF_W     = MAX_LOG;

  typedef struct packed {
    logic accept;
    logic overwrite;
    logic drop;
    logic wrCtl;
    logic wrBaseHi;
    logic wrBaseLo;
    logic wrRdOff;
  } ringStb_t;

  function automatic logic [OFF_W-1:0] sizeMask(input logic [CODE_W-1:0] code);
    logic [OFF_W:0] full;
    full = ({{OFF_W{1'b0}}, 1'b1} << (MIN_LOG + int'(code))) - 1'b1;
    return full[OFF_W-1:0] & ~{{(OFF_W-ENTRY_LOG){1'b0}}, {ENTRY_LOG{1'b1}}};
  endfunction
endpackage

// File: rtl/msi_ring_ctl.sv
module msi_ring_ctl
  import msi_ring_pkg::*;
(
  input  logic       msiValid,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic       capEn,
  input  logic       stopEn,
  input  logic       irqEn,
  input  logic       qFull,
  input  logic       qEmpty,
  output ringStb_t   stb,
  output logic       irqOut
);
  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_BHI  = 3'd3;
  localparam logic [2:0] A_BLO  = 3'd4;
  localparam logic [2:0] A_RDOF = 3'd5;

  logic live;
  logic blocked;

  always_comb begin
    live    = msiValid && capEn;
    blocked = qFull && stopEn;
    stb = '0;
    stb.accept    = live && !blocked;
    stb.overwrite = live && !blocked && qFull;
    stb.drop      = live && blocked;
    stb.wrCtl     = regWrEn && (regAddr == A_CTL);
    stb.wrBaseHi  = regWrEn && (regAddr == A_BHI);
    stb.wrBaseLo  = regWrEn && (regAddr == A_BLO);
    stb.wrRdOff   = regWrEn && (regAddr == A_RDOF);
    irqOut = irqEn && !qEmpty;
  end
endmodule

// File: rtl/msi_ring_dp.sv
module msi_ring_dp
  import msi_ring_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 64,
  parameter int ENT_W  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStb_t          stb,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [REG_W-1:0]  msiData,
  output logic [REG_W-1:0]  regRdData,
  output logic              capEn,
  output logic              stopEn,
  output logic              irqEn,
  output logic              qFull,
  output logic              qEmpty,
  output logic [OFF_W-1:0]  wrOff,
  output logic [OFF_W-1:0]  rdOff,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [ENT_W-1:0]  memWrData
);
  localparam int HALF_W = ADDR_W / 2;
  localparam logic [OFF_W-1:0] STEP = OFF_W'(1 << ENTRY_LOG);

  logic              fullEn;
  logic [CODE_W-1:0] sizeCode;
  logic              ovfFlag;
  logic [HALF_W-1:0] baseHi;
  logic [HALF_W-1:0] baseLo;

  logic [OFF_W-1:0] curMask;
  logic [OFF_W-1:0] newMask;
  logic [OFF_W-1:0] wrInc;
  logic [OFF_W-1:0] rdInc;
  logic [OFF_W-1:0] nextWr;
  logic [OFF_W-1:0] nextRd;

  always_comb begin
    curMask = sizeMask(sizeCode);
    newMask = stb.wrCtl ? sizeMask(regWrData[9:8]) : curMask;
    wrInc   = (wrOff + STEP) & curMask;
    rdInc   = (rdOff + STEP) & curMask;
    qFull   = (wrInc == rdOff);
    qEmpty  = (wrOff == rdOff);

    nextWr = stb.accept ? wrInc : wrOff;
    if (stb.wrRdOff)        nextRd = regWrData[OFF_W-1:0] & curMask;
    else if (stb.overwrite) nextRd = rdInc;
    else                    nextRd = rdOff;
    nextWr = nextWr & newMask;
    nextRd = nextRd & newMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capEn      <= 1'b0;
      fullEn     <= 1'b0;
      irqEn      <= 1'b0;
      stopEn     <= 1'b0;
      sizeCode   <= '0;
      ovfFlag    <= 1'b0;
      baseHi     <= '0;
      baseLo     <= '0;
      wrOff      <= '0;
      rdOff      <= '0;
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
    end else begin
      if (stb.wrCtl) begin
        capEn    <= regWrData[0];
        fullEn   <= regWrData[1];
        irqEn    <= regWrData[3];
        stopEn   <= regWrData[4];
        sizeCode <= regWrData[9:8];
      end
      if (stb.drop)                          ovfFlag <= 1'b1;
      else if (stb.wrCtl && regWrData[31])   ovfFlag <= 1'b0;
      if (stb.wrBaseHi) baseHi <= regWrData[HALF_W-1:0];
      if (stb.wrBaseLo) baseLo <= regWrData[HALF_W-1:0];
      wrOff      <= nextWr;
      rdOff      <= nextRd;
      memWrValid <= stb.accept;
      if (stb.accept) begin
        memWrAddr <= {baseHi, baseLo} + ADDR_W'(wrOff);
        memWrData <= {{(ENT_W-REG_W){1'b0}}, msiData};
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      3'd0: begin
        regRdData[0]   = capEn;
        regRdData[1]   = fullEn;
        regRdData[3]   = irqEn;
        regRdData[4]   = stopEn;
        regRdData[9:8] = sizeCode;
        regRdData[30]  = fullEn && qFull;
        regRdData[31]  = ovfFlag;
      end
      3'd3:    regRdData = REG_W'(baseHi);
      3'd4:    regRdData = REG_W'(baseLo);
      3'd5:    regRdData = REG_W'(rdOff);
      3'd6:    regRdData = REG_W'(wrOff);
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
  import msi_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         msiValid,
  input  logic [31:0]  msiData,
  input  logic         regWrEn,
  input  logic [2:0]   regAddr,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  output logic         memWrValid,
  output logic [63:0]  memWrAddr,
  output logic [127:0] memWrData,
  output logic         irqOut
);
  ringStb_t         stb;
  logic             capEn;
  logic             stopEn;
  logic             irqEn;
  logic             qFull;
  logic             qEmpty;
  logic [OFF_W-1:0] wrOff;
  logic [OFF_W-1:0] rdOff;

  msi_ring_ctl u_ctl (
    .msiValid (msiValid),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .capEn    (capEn),
    .stopEn   (stopEn),
    .irqEn    (irqEn),
    .qFull    (qFull),
    .qEmpty   (qEmpty),
    .stb      (stb),
    .irqOut   (irqOut)
  );

  msi_ring_dp #(.REG_W(32), .ADDR_W(64), .ENT_W(128)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .msiData    (msiData),
    .regRdData  (regRdData),
    .capEn      (capEn),
    .stopEn     (stopEn),
    .irqEn      (irqEn),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .wrOff      (wrOff),
    .rdOff      (rdOff),
    .memWrValid (memWrValid),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );
endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk
  import msi_ring_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             msiValid,
  input logic             memWrValid,
  input logic             irqOut,
  input logic             capEn,
  input logic             stopEn,
  input logic             irqEn,
  input logic             qFull,
  input logic [OFF_W-1:0] wrOff,
  input logic [OFF_W-1:0] rdOff
);
  AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (wrOff[ENTRY_LOG-1:0] == '0) && (rdOff[ENTRY_LOG-1:0] == '0)); // R6

  AST_WRITE_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> (wrOff != $past(wrOff))); // R4

  AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (msiValid && !capEn) |=> !memWrValid); // R5

  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (msiValid && capEn && stopEn && qFull) |=> !memWrValid); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut); // R10

  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (wrOff == rdOff) |-> !irqOut); // R10
endmodule

bind msi_ring_ctrl msi_ring_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .msiValid   (msiValid),
  .memWrValid (memWrValid),
  .irqOut     (irqOut),
  .capEn      (capEn),
  .stopEn     (stopEn),
  .irqEn      (irqEn),
  .qFull      (qFull),
  .wrOff      (wrOff),
  .rdOff      (rdOff)
);

// File: tb/msi_ring_ctrl_tb.sv
module msi_ring_ctrl_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         msiValid = 1'b0;
  logic [31:0]  msiData = '0;
  logic         regWrEn = 1'b0;
  logic [2:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         memWrValid;
  logic [63:0]  memWrAddr;
  logic [127:0] memWrData;
  logic         irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // model state
  bit        mCap, mFullEn, mIrq, mStop, mOvf;
  bit [1:0]  mCode;
  bit [31:0] mHi, mLo, mRd, mWr;

  always #10 clk = ~clk;

  msi_ring_ctrl u_dut (
    .clk(clk), .rstN(rstN), .msiValid(msiValid), .msiData(msiData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .irqOut(irqOut)
  );

  function automatic bit [31:0] maskOf(input bit [1:0] code);
    return ((32'd1 << (15 + code)) - 32'd1) & 32'hFFFF_FFF0;
  endfunction

  function automatic bit mFull();
    return ((mWr + 32'd16) & maskOf(mCode)) == mRd;
  endfunction

  function automatic bit [31:0] expCtl();
    bit [31:0] v = '0;
    v[0] = mCap; v[1] = mFullEn; v[3] = mIrq; v[4] = mStop;
    v[9:8] = mCode; v[30] = mFullEn && mFull(); v[31] = mOvf;
    return v;
  endfunction

  function automatic bit [31:0] expReg(input bit [2:0] a);
    case (a)
      3'd0: return expCtl();
      3'd3: return mHi;
      3'd4: return mLo;
      3'd5: return mRd;
      3'd6: return mWr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, check registered outputs after posedge
  task automatic doCycle(input bit msi, input bit [31:0] d, input bit we,
                         input bit [2:0] a, input bit [31:0] wd, input string req);
    bit acc, ovw, drp;
    bit [63:0] eAddr;
    bit [31:0] nm;
    @(negedge clk);
    msiValid = msi; msiData = d; regWrEn = we; regAddr = a; regWrData = wd;
    acc = msi && mCap && !(mFull() && mStop);
    ovw = acc && mFull();
    drp = msi && mCap && mFull() && mStop;
    eAddr = {mHi, mLo} + {32'd0, mWr};
    @(posedge clk);
    // model update
    nm = (we && a == 3'd0) ? maskOf(wd[9:8]) : maskOf(mCode);
    if (we && a == 3'd5) mRd = wd & maskOf(mCode);
    else if (ovw) mRd = (mRd + 32'd16) & maskOf(mCode);
    if (acc) mWr = (mWr + 32'd16) & maskOf(mCode);
    if (drp) mOvf = 1'b1;
    else if (we && a == 3'd0 && wd[31]) mOvf = 1'b0;
    if (we && a == 3'd0) begin
      mCap = wd[0]; mFullEn = wd[1]; mIrq = wd[3]; mStop = wd[4]; mCode = wd[9:8];
    end
    if (we && a == 3'd3) mHi = wd;
    if (we && a == 3'd4) mLo = wd;
    mRd = mRd & nm; mWr = mWr & nm;
    #1;
    msiValid = 1'b0; regWrEn = 1'b0;
    check(memWrValid == acc, {req, " memWrValid"}, 128'(memWrValid), 128'(acc));
    if (acc) begin
      check(memWrAddr == eAddr, {req, " memWrAddr"}, 128'(memWrAddr), 128'(eAddr));
      check(memWrData == {96'd0, d}, {req, " memWrData"}, memWrData, {96'd0, d});
    end
    check(irqOut == (mIrq && (mRd != mWr)), "R10 irqOut", 128'(irqOut), 128'(mIrq && (mRd != mWr)));
  endtask

  task automatic readCheck(input bit [2:0] a, input string req);
    regAddr = a;
    #1;
    check(regRdData == expReg(a), req, 128'(regRdData), 128'(expReg(a)));
  endtask

  task automatic readAll(input string req);
    readCheck(3'd0, req); readCheck(3'd3, req); readCheck(3'd4, req);
    readCheck(3'd5, req); readCheck(3'd6, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    readAll("R1 reset regs");
    check(irqOut == 1'b0, "R1 irqOut", 128'(irqOut), 128'd0);
    check(memWrValid == 1'b0, "R1 memWrValid", 128'(memWrValid), 128'd0);

    // R2: unmapped and read-only addresses
    doCycle(0, 0, 1, 3'd1, 32'hDEAD_BEEF, "R2 unmapped");
    doCycle(0, 0, 1, 3'd7, 32'h1234_5678, "R2 unmapped");
    doCycle(0, 0, 1, 3'd6, 32'h0000_0040, "R2 wr offset read-only");
    readCheck(3'd1, "R2 addr1 reads zero");
    readCheck(3'd7, "R2 addr7 reads zero");
    readAll("R2 regs unchanged");

    // R5: capture disabled
    doCycle(1, 32'h0000_0042, 0, 0, 0, "R5 disabled");
    readAll("R5 offsets unchanged");

    // R3: configure
    doCycle(0, 0, 1, 3'd3, 32'h0000_1234, "R3 base hi");
    doCycle(0, 0, 1, 3'd4, 32'h8000_0000, "R3 base lo");
    doCycle(0, 0, 1, 3'd0, 32'h0000_000B, "R3 ctl");
    readAll("R3 readback");

    // R4: entries
    doCycle(1, 32'h0000_0011, 0, 0, 0, "R4 entry");
    doCycle(1, 32'hCAFE_0022, 0, 0, 0, "R4 entry");
    doCycle(1, 32'h0000_0033, 0, 0, 0, "R4 entry");
    readCheck(3'd6, "R4 wr offset");
    // R10: consume to empty
    doCycle(0, 0, 1, 3'd5, 32'h10, "R10 consume");
    doCycle(0, 0, 1, 3'd5, 32'h30, "R10 caught up");

    // R6: masking
    doCycle(0, 0, 1, 3'd5, 32'hFFFF_FFFF, "R6 mask");
    readCheck(3'd5, "R6 rd offset masked");

    // R8: full with stop
    doCycle(0, 0, 1, 3'd0, 32'h0000_001B, "R8 stop on");
    doCycle(0, 0, 1, 3'd5, 32'h40, "R8 make full");
    readCheck(3'd0, "R3 full flag");
    doCycle(1, 32'h0000_0099, 0, 0, 0, "R8 drop");
    readAll("R8 overflow set");
    doCycle(0, 0, 1, 3'd0, 32'h8000_000B, "R3 clear ovf");
    readCheck(3'd0, "R3 ovf cleared");

    // R9: overwrite
    doCycle(1, 32'h0000_0077, 0, 0, 0, "R9 overwrite");
    readAll("R9 offsets moved");

    // R11: software write wins over overwrite advance
    doCycle(1, 32'h0000_0088, 1, 3'd5, 32'h0000_0060, "R11 same cycle");
    readAll("R11 rd offset");

    // R7: size change re-masks
    doCycle(0, 0, 1, 3'd0, 32'h0000_030B, "R7 size 256K");
    doCycle(0, 0, 1, 3'd5, 32'h0003_FFF0, "R7 big rd");
    readCheck(3'd5, "R7 big rd stored");
    doCycle(0, 0, 1, 3'd0, 32'h0000_000B, "R7 shrink");
    readAll("R7 remasked");

    // R4: wrap in 32 KB queue
    for (int i = 0; i < 2100; i++) doCycle(1, $urandom, 0, 0, 0, "R4 wrap");
    readAll("R4 after wrap");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 55) doCycle(1, $urandom, 0, 0, 0, "R9 random msi");
      else if (r < 75) doCycle(0, 0, 1, 3'd5, mRd + 32'd16, "R6 random consume");
      else if (r < 80) doCycle(0, 0, 1, 3'd5, $urandom, "R6 random rd");
      else if (r < 84) doCycle(0, 0, 1, 3'd0,
                               ($urandom & 32'h8000_031A) | 32'h1, "R7 random ctl");
      else if (r < 88) doCycle(1, $urandom, 1, 3'd5, (mWr + 32'd16), "R11 random");
      else if (r < 90) doCycle(0, 0, 1, 3'($urandom_range(0, 7)), $urandom, "R2 random write");
      else doCycle(0, 0, 0, 0, 0, "R10 idle");
      if (r >= 95) readAll("R3 random readback");
    end
    readAll("R8 final");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule